// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block collects eight interrupt request lines, picks the most urgent pending one by fixed priority, and raises a single interrupt output toward a processor. Software reaches it through a byte-wide port with two addresses. Address bit 0 low is the command port and address bit 0 high is the data port. A command-port write with bit 4 set starts a programming sequence. The next three data-port writes supply the vector base, the cascade word and a mode word. After that, the data port reads and writes the mask register, and the command port takes end-of-interrupt, read-select and poll commands.

Acknowledgement is done by polling. Software writes the poll command, and the next command-port read returns the winning request number with bit 7 set. That read also moves the request from the pending register into the in-service register. Two copies can form a cascade by wiring the slave's interrupt output to master input 2. Software then polls the master, sees input 2, polls the slave, and finishes by sending an end-of-interrupt to the slave and then one to the master. A poll that finds nothing returns 0x07 with bit 7 clear. In-service bit 7 stays clear in that case, which is how software recognises a spurious lowest-priority report.

Top module: `cpic_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the command port reads the pending register as 0x00, and `int_out` is low.
- R2: A command write with bit 4 set clears the mask, the in-service register, the pending register, any armed poll, and the read selection (back to pending). The next three data writes are taken as the vector base, the cascade word (shown on `cascade_word`) and the mode word, and none of them reaches the mask.
- R3: Once programming is complete, data-port reads return the mask and data-port writes load it. Mask bit n = 1 keeps input n from raising `int_out` or winning a poll.
- R4: A request is latched only on a rising edge of its input. A latched request survives being masked, and an input held high raises no second request after it has been acknowledged.
- R5: Input 0 has the highest priority and input 7 the lowest. A request is eligible only if it is unmasked and no in-service bit of equal or higher priority is set.
- R6: `int_out` is high in exactly those cycles in which at least one eligible request exists.
- R7: After the command write 0x0C, the next command-port read returns 0x80 | n for the winning input n, sets in-service bit n and clears pending bit n. Later command reads return the selected register again.
- R8: A poll read with no eligible request returns 0x07 and changes no in-service bit, so in-service bit 7 reads clear.
- R9: The command write 0x20 clears the highest-priority set bit of the in-service register. Other writes with bit 3 clear and bits 7:5 not equal to 001 change nothing.
- R10: The command write 0x0B selects the in-service register and 0x0A selects the pending register for command reads. A command write with bit 3 set and bit 1 clear keeps the current selection.
- R11: `pend_vector` equals the vector base with bits 2:0 replaced by the winning input number, or by 7 when no request is eligible.
- R12: With the slave's `int_out` wired to master input 2, a slave request makes the master poll return 0x82 and the slave poll return the slave input. An end-of-interrupt to the slave followed by one to the master leaves both in-service registers empty.
- R13: While the programming sequence is still running, command writes with bit 4 clear are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Device select for the register port |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr0 | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while sel and rd_en are high, else 0 |
| irq_in | input | 8 | Request inputs, rising-edge sensitive |
| int_out | output | 1 | Interrupt output toward the processor or master |
| pend_vector | output | 8 | Vector base combined with the current winner |
| cascade_word | output | 8 | Cascade word taken during programming |

## Verification
Requests are applied as single pulses, as levels held across their acknowledgement, as pulses that arrive while masked, as two simultaneous edges, and as a lower-priority edge that arrives while a higher one is in service. Together these separate edge latching from level sensing, fixed priority from arrival order, and blocking by the mask from blocking by the in-service register. Polls are issued with requests pending, with nothing pending (the spurious case), and across a master/slave pair. Programming is interleaved with stray commands and with an in-service bit left set, to show what that sequence resets and what it ignores.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
  localparam int NUM_IN = 8;
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(NUM_IN);

  typedef logic [NUM_IN-1:0] vec_t;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_BASE = 2'd1,
    PH_CASC = 2'd2,
    PH_MODE = 2'd3
  } phase_e;

  // {found, index} of the lowest-numbered (highest priority) set bit
  function automatic logic [IDX_W:0] first_set(vec_t v);
    logic [IDX_W:0] r;
    r = {1'b0, {IDX_W{1'b1}}};
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  // bits whose priority is strictly above every in-service bit
  function automatic vec_t above_service(vec_t isr);
    vec_t m;
    logic hit;
    m   = '0;
    hit = 1'b0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (isr[i]) hit = 1'b1;
      if (!hit) m[i] = 1'b1;
    end
    return m;
  endfunction

  // clear the lowest set bit
  function automatic vec_t drop_top(vec_t v);
    return v & (v - vec_t'(1));
  endfunction

  function automatic vec_t onehot(logic [IDX_W-1:0] idx);
    return vec_t'(1) << idx;
  endfunction
endpackage

// File: rtl/cpic_regs.sv
module cpic_regs
  import cpic_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_cmd,
  input  logic                    wr_data,
  input  logic                    rd_cmd,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    init_ev,
  output logic                    eoi_ev,
  output logic                    poll_rd_ev,
  output vec_t                    mask,
  output logic [DATA_W-IDX_W-1:0] base_hi,
  output logic [DATA_W-1:0]       casc,
  output logic                    rd_isr_sel,
  output logic                    poll_q
);
  phase_e phase;
  logic   running;
  logic   ocw_wr;
  logic   ocw3_wr;

  assign running    = (phase == PH_RUN);
  assign init_ev    = wr_cmd && wdata[4];
  assign ocw_wr     = wr_cmd && !wdata[4] && running;
  assign ocw3_wr    = ocw_wr && wdata[3];
  assign eoi_ev     = ocw_wr && !wdata[3] && (wdata[7:5] == 3'b001);
  assign poll_rd_ev = rd_cmd && poll_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_RUN;
      mask       <= '1;
      base_hi    <= '0;
      casc       <= '0;
      rd_isr_sel <= 1'b0;
      poll_q     <= 1'b0;
    end else if (init_ev) begin
      phase      <= PH_BASE;
      mask       <= '0;
      rd_isr_sel <= 1'b0;
      poll_q     <= 1'b0;
    end else begin
      if (wr_data) begin
        unique case (phase)
          PH_BASE: begin
            base_hi <= wdata[DATA_W-1:IDX_W];
            phase   <= PH_CASC;
          end
          PH_CASC: begin
            casc  <= wdata;
            phase <= PH_MODE;
          end
          PH_MODE: phase <= PH_RUN;
          default: mask <= vec_t'(wdata);
        endcase
      end
      if (ocw3_wr) begin
        if (wdata[1]) rd_isr_sel <= wdata[0];
        if (wdata[2]) poll_q <= 1'b1;
      end
      if (poll_rd_ev) poll_q <= 1'b0;
    end
  end

  a_r2_init_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
    init_ev |=> (mask == '0) && !poll_q && !rd_isr_sel);

  a_r13_cmd_ignored_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && wr_cmd && !wdata[4]) |=> $stable(rd_isr_sel) && $stable(poll_q));

  a_r7_poll_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd_ev |=> !poll_q);
endmodule

// File: rtl/cpic_request.sv
module cpic_request
  import cpic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  vec_t irq_in,
  input  logic clr_all,
  input  vec_t ack_vec,
  output vec_t irr
);
  vec_t prev;
  vec_t rise;

  assign rise = irq_in & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      if (clr_all) irr <= '0;
      else         irr <= (irr & ~ack_vec) | rise;
    end
  end

  a_r4_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irr) & ~($past(irq_in) & ~$past(prev))) == '0));
endmodule

// File: rtl/cpic_inservice.sv
module cpic_inservice
  import cpic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_all,
  input  vec_t set_vec,
  input  logic eoi,
  output vec_t isr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       isr <= '0;
    else if (clr_all) isr <= '0;
    else if (eoi)     isr <= drop_top(isr);
    else              isr <= isr | set_vec;
  end

  a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !clr_all && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

  a_r7_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0 && !clr_all && !eoi) |=> ((isr & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/cpic_ctrl.sv
module cpic_ctrl
  import cpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              int_out,
  output logic [DATA_W-1:0] pend_vector,
  output logic [DATA_W-1:0] cascade_word
);
  logic                    wr_cmd, wr_data, rd_cmd, rd_any;
  logic                    init_ev, eoi_ev, poll_rd_ev;
  logic                    rd_isr_sel, poll_q;
  vec_t                    mask, irr, isr, elig, ack_vec;
  logic [DATA_W-IDX_W-1:0] base_hi;
  logic [DATA_W-1:0]       casc, poll_byte;
  logic [IDX_W:0]          win;
  logic                    has_win;
  logic [IDX_W-1:0]        win_idx;

  assign wr_cmd  = sel && wr_en && !addr0;
  assign wr_data = sel && wr_en && addr0;
  assign rd_cmd  = sel && rd_en && !addr0;
  assign rd_any  = sel && rd_en;

  cpic_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cmd     (wr_cmd),
    .wr_data    (wr_data),
    .rd_cmd     (rd_cmd),
    .wdata      (wdata),
    .init_ev    (init_ev),
    .eoi_ev     (eoi_ev),
    .poll_rd_ev (poll_rd_ev),
    .mask       (mask),
    .base_hi    (base_hi),
    .casc       (casc),
    .rd_isr_sel (rd_isr_sel),
    .poll_q     (poll_q)
  );

  cpic_request u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .clr_all (init_ev),
    .ack_vec (ack_vec),
    .irr     (irr)
  );

  cpic_inservice u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (init_ev),
    .set_vec (ack_vec),
    .eoi     (eoi_ev),
    .isr     (isr)
  );

  assign elig    = irr & ~mask & above_service(isr);
  assign win     = first_set(elig);
  assign has_win = win[IDX_W];
  assign win_idx = win[IDX_W-1:0];
  assign ack_vec = (poll_rd_ev && has_win) ? onehot(win_idx) : '0;

  assign poll_byte = has_win ? {1'b1, {(DATA_W-1-IDX_W){1'b0}}, win_idx}
                             : DATA_W'(NUM_IN - 1);

  always_comb begin
    if (!rd_any)          rdata = '0;
    else if (addr0)       rdata = DATA_W'(mask);
    else if (poll_q)      rdata = poll_byte;
    else if (rd_isr_sel)  rdata = DATA_W'(isr);
    else                  rdata = DATA_W'(irr);
  end

  assign int_out      = has_win;
  assign pend_vector  = {base_hi, win_idx};
  assign cascade_word = casc;

  a_r6_int_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  a_r5_ack_outranks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0) |-> ((isr & (ack_vec | (ack_vec - vec_t'(1)))) == '0));

  a_r8_empty_poll_keeps_service: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd_ev && !int_out && !init_ev) |=> $stable(isr));

  a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));
endmodule

// File: tb/cpic_ctrl_tb.sv
module cpic_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_m = 1'b0, sel_s = 1'b0, wr = 1'b0, rd = 1'b0, a0 = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] irq_m = 8'h00, irq_s = 8'h00;
  logic [7:0] rd_m, rd_s, pv_m, pv_s, cw_m, cw_s;
  logic       int_m, int_s;
  logic [7:0] m_irq_in;
  logic [7:0] last_m, last_s;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign m_irq_in = {irq_m[7:3], int_s, irq_m[1:0]};

  cpic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sel(sel_m), .wr_en(wr), .rd_en(rd), .addr0(a0),
    .wdata(wd), .rdata(rd_m), .irq_in(m_irq_in), .int_out(int_m),
    .pend_vector(pv_m), .cascade_word(cw_m));

  cpic_ctrl u_slv (
    .clk(clk), .rst_n(rst_n), .sel(sel_s), .wr_en(wr), .rd_en(rd), .addr0(a0),
    .wdata(wd), .rdata(rd_s), .irq_in(irq_s), .int_out(int_s),
    .pend_vector(pv_s), .cascade_word(cw_s));

  // behavioural reference: index 0 master, 1 slave
  bit [7:0] m_prev[2], m_mask[2], m_isr[2], m_irr[2], m_base[2], m_casc[2];
  int       m_ph[2];
  bit       m_rsel[2], m_poll[2];

  function automatic int best(int d);
    for (int i = 0; i < 8; i++) begin
      if (m_isr[d][i]) return -1;
      if (m_irr[d][i] && !m_mask[d][i]) return i;
    end
    return -1;
  endfunction

  function automatic bit [7:0] exp_rd(int d);
    int b;
    b = best(d);
    if (a0) return m_mask[d];
    if (m_poll[d]) return (b >= 0) ? (8'h80 + 8'(b)) : 8'h07;
    return m_rsel[d] ? m_isr[d] : m_irr[d];
  endfunction

  function automatic bit [7:0] exp_pv(int d);
    int b;
    b = best(d);
    return {m_base[d][7:3], (b >= 0) ? 3'(b) : 3'd7};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic upd(int d, bit s, bit [7:0] irqv);
    bit [7:0] rise;
    int b;
    rise = irqv & ~m_prev[d];
    m_prev[d] = irqv;
    b = best(d);
    if (s && wr && !a0 && wd[4]) begin
      m_ph[d] = 1; m_mask[d] = 0; m_isr[d] = 0; m_irr[d] = 0;
      m_rsel[d] = 0; m_poll[d] = 0;
      return;
    end
    if (s && wr && a0) begin
      case (m_ph[d])
        1: begin m_base[d] = wd; m_ph[d] = 2; end
        2: begin m_casc[d] = wd; m_ph[d] = 3; end
        3: m_ph[d] = 0;
        default: m_mask[d] = wd;
      endcase
    end else if (s && wr && !a0 && m_ph[d] == 0) begin
      if (wd[3]) begin
        if (wd[1]) m_rsel[d] = wd[0];
        if (wd[2]) m_poll[d] = 1;
      end else if (wd[7:5] == 3'b001) begin
        for (int i = 0; i < 8; i++)
          if (m_isr[d][i]) begin m_isr[d][i] = 0; break; end
      end
    end else if (s && rd && !a0 && m_poll[d]) begin
      m_poll[d] = 0;
      if (b >= 0) begin m_isr[d][b] = 1; m_irr[d][b] = 0; end
    end
    m_irr[d] = m_irr[d] | rise;
  endtask

  // one clock: compare outputs against the model, then advance it
  task automatic cyc();
    bit s_exp;
    #1;
    chk("R6 int_out master", {7'd0, int_m}, {7'd0, best(0) >= 0});
    chk("R6 int_out slave",  {7'd0, int_s}, {7'd0, best(1) >= 0});
    chk("R11 pend_vector master", pv_m, exp_pv(0));
    chk("R11 pend_vector slave",  pv_s, exp_pv(1));
    chk("R2 cascade_word master", cw_m, m_casc[0]);
    chk("R2 cascade_word slave",  cw_s, m_casc[1]);
    if (rd && sel_m) chk(a0 ? "R3 data read m" : (m_poll[0] ? "R7 poll read m" : "R10 cmd read m"), rd_m, exp_rd(0));
    if (rd && sel_s) chk(a0 ? "R3 data read s" : (m_poll[1] ? "R7 poll read s" : "R10 cmd read s"), rd_s, exp_rd(1));
    last_m = rd_m;
    last_s = rd_s;
    s_exp = (best(1) >= 0);
    upd(1, sel_s, irq_s);
    upd(0, sel_m, {irq_m[7:3], s_exp, irq_m[1:0]});
    @(negedge clk);
    sel_m = 0; sel_s = 0; wr = 0; rd = 0; a0 = 0;
  endtask

  task automatic pick(int d);
    sel_m = (d == 0);
    sel_s = (d == 1);
  endtask
  task automatic wcmd(int d, logic [7:0] v);
    pick(d); wr = 1; a0 = 0; wd = v; cyc();
  endtask
  task automatic wdat(int d, logic [7:0] v);
    pick(d); wr = 1; a0 = 1; wd = v; cyc();
  endtask
  task automatic rcmd(int d);
    pick(d); rd = 1; a0 = 0; cyc();
  endtask
  task automatic rdat(int d);
    pick(d); rd = 1; a0 = 1; cyc();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic prog(int d, logic [7:0] b, logic [7:0] c);
    wcmd(d, 8'h11); wdat(d, b); wdat(d, c); wdat(d, 8'h01);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      m_prev[d] = 0; m_mask[d] = 8'hFF; m_isr[d] = 0; m_irr[d] = 0;
      m_base[d] = 0; m_casc[d] = 0; m_ph[d] = 0; m_rsel[d] = 0; m_poll[d] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdat(0); chk("R1 mask after reset", last_m, 8'hFF);
    rcmd(0); chk("R1 pending after reset", last_m, 8'h00);
    chk("R1 int low", {7'd0, int_m}, 8'h00);

    // R2 programming
    prog(0, 8'h00, 8'h04);
    rdat(0); chk("R2 mask cleared by programming", last_m, 8'h00);
    chk("R2 master cascade word", cw_m, 8'h04);
    prog(1, 8'h08, 8'h02);
    chk("R2 slave cascade word", cw_s, 8'h02);
    chk("R11 slave idle vector", pv_s, 8'h0F);

    // R3/R4 masked edge stays latched
    wdat(0, 8'hFF);
    irq_m[5] = 1; idle(2);
    chk("R3 masked input keeps int low", {7'd0, int_m}, 8'h00);
    rcmd(0); chk("R4 masked edge latched", last_m, 8'h20);
    wdat(0, 8'h00); cyc();
    chk("R6 int after unmask", {7'd0, int_m}, 8'h01);
    rdat(0); chk("R3 mask readback", last_m, 8'h00);

    // R7 poll, R10 select, R4 held level
    wcmd(0, 8'h0C); rcmd(0); chk("R7 poll returns input 5", last_m, 8'h85);
    rcmd(0); chk("R7 second read is pending reg", last_m, 8'h00);
    wcmd(0, 8'h0B); rcmd(0); chk("R10 in-service read", last_m, 8'h20);
    idle(2); chk("R4 held level no new request", {7'd0, int_m}, 8'h00);

    // R5 priority against in-service, R9 end-of-interrupt
    irq_m[6] = 1; idle(2);
    chk("R5 lower priority blocked", {7'd0, int_m}, 8'h00);
    irq_m[3] = 1; idle(2);
    chk("R5 higher priority passes", {7'd0, int_m}, 8'h01);
    chk("R11 master vector", pv_m, 8'h03);
    wcmd(0, 8'h0C); rcmd(0); chk("R7 poll returns input 3", last_m, 8'h83);
    rcmd(0); chk("R10 selection persists", last_m, 8'h28);
    wcmd(0, 8'h20); rcmd(0); chk("R9 eoi clears bit 3", last_m, 8'h20);
    wcmd(0, 8'h60); rcmd(0); chk("R9 other code ignored", last_m, 8'h20);
    wcmd(0, 8'h20); rcmd(0); chk("R9 eoi clears bit 5", last_m, 8'h00);
    chk("R11 vector input 6", pv_m, 8'h06);
    wcmd(0, 8'h0C); rcmd(0); chk("R7 poll returns input 6", last_m, 8'h86);
    wcmd(0, 8'h20);

    // R8 spurious
    wcmd(0, 8'h0C); rcmd(0); chk("R8 empty poll", last_m, 8'h07);
    rcmd(0); chk("R8 in-service bit 7 clear", last_m, 8'h00);

    // R10 selection changes, R8 genuine input 7
    wdat(0, 8'h80);
    irq_m[7] = 1; cyc();
    wcmd(0, 8'h0A); rcmd(0); chk("R10 pending select", last_m, 8'h80);
    wcmd(0, 8'h08); rcmd(0); chk("R10 selection kept", last_m, 8'h80);
    wdat(0, 8'h00);
    wcmd(0, 8'h0C); rcmd(0); chk("R8 genuine input 7", last_m, 8'h87);
    wcmd(0, 8'h0B); rcmd(0); chk("R8 in-service bit 7 set", last_m, 8'h80);
    wcmd(0, 8'h20);
    irq_m = 8'h00; cyc();

    // R12 cascade
    irq_s[1] = 1; cyc(); irq_s[1] = 0; idle(3);
    chk("R12 slave int", {7'd0, int_s}, 8'h01);
    chk("R12 master int", {7'd0, int_m}, 8'h01);
    wcmd(0, 8'h0C); rcmd(0); chk("R12 master reports 2", last_m, 8'h82);
    wcmd(1, 8'h0C); rcmd(1); chk("R12 slave reports 1", last_s, 8'h81);
    rcmd(0); chk("R12 master in-service", last_m, 8'h04);
    wcmd(1, 8'h0B); rcmd(1); chk("R12 slave in-service", last_s, 8'h02);
    wcmd(1, 8'h20); wcmd(0, 8'h20);
    rcmd(0); chk("R12 master cleared", last_m, 8'h00);
    rcmd(1); chk("R12 slave cleared", last_s, 8'h00);

    // R5 simultaneous edges
    irq_m = 8'h12; cyc(); irq_m = 8'h00; idle(2);
    chk("R11 vector input 1", pv_m, 8'h01);
    wcmd(0, 8'h0C); rcmd(0); chk("R5 input 1 first", last_m, 8'h81);
    wcmd(0, 8'h20);
    wcmd(0, 8'h0C); rcmd(0); chk("R5 input 4 next", last_m, 8'h84);
    wcmd(0, 8'h20);

    // R2 clears service, R13 stray command during programming
    irq_m[0] = 1; cyc(); irq_m[0] = 0; cyc();
    wcmd(0, 8'h0C); rcmd(0); chk("R7 poll returns input 0", last_m, 8'h80);
    wcmd(0, 8'h11); wcmd(0, 8'h0C); wdat(0, 8'h00); wdat(0, 8'h04); wdat(0, 8'h01);
    rcmd(0); chk("R13 poll ignored during programming", last_m, 8'h00);
    rdat(0); chk("R2 data words kept off mask", last_m, 8'h00);
    wcmd(0, 8'h0B); rcmd(0); chk("R2 in-service cleared", last_m, 8'h00);
    idle(2);

    finish_run();
  end
endmodule